// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It reads short-format translation tables that are stored in memory. A one-cycle start pulse launches a walk. The walk selects one of two table bases by comparing the address against a programmable upper bound. It fetches the first-level entry and decodes it. When that entry points to a second-level table, it fetches that entry as well. A memory read port with a valid/ready request and a response strobe carries at most one word read at a time.

The result comes out as a one-cycle completion pulse. The physical address, a fault flag and a two-bit cause code are valid in that same cycle. First-level entries can map a 1 MiB section or a 16 MiB supersection, or they can point to a second-level table. Second-level entries map a 64 KiB large page or a 4 KiB small page. An entry with type bits 00 at either level is a translation fault.

Top module: `xlat_walker`

## Requirements
- R1: The walk uses base 1 only when the virtual address is strictly greater than `limit0_i`. In every other case, including equality, it uses base 0.
- R2: The first read address is (selected base AND its mask) OR (bits [31:20] of the masked VA, placed at address bits [13:2]). For base 0 the VA is masked by `limit0_i`. For base 1 the VA is not masked.
- R3: A first-level entry with bits [1:0] = 00 ends the walk after that single read, with fault = 1 and cause = 1.
- R4: A first-level entry with bit 1 = 1 and bit 18 = 0 is a section. The physical address is {entry[31:20], VA[19:0]}.
- R5: A first-level entry with bit 1 = 1 and bit 18 = 1 is a supersection. The physical address is {entry[31:24], VA[23:0]}.
- R6: A supersection entry with any bit set in [23:20] or [8:5] faults with cause = 3, and no second read is made.
- R7: A first-level entry with bits [1:0] = 01 leads to a second read at {entry[31:10], VA[19:12], 2'b00}.
- R8: A second-level entry with bits [1:0] = 00 faults with cause = 2.
- R9: A second-level entry with bits [1:0] = 01 is a large page. The physical address is {entry[31:16], VA[15:0]}.
- R10: A second-level entry with bit 1 = 1 is a small page. The physical address is {entry[31:12], VA[11:0]}.
- R11: A request is held with a stable address until `mem_req_ready_i` is sampled high. No new request is raised while a read is outstanding.
- R12: `done_o` rises for exactly one cycle, in the cycle after the final response is sampled. On success, fault = 0 and cause = 0. On a fault, `pa_o` = 0.
- R13: `busy_o` is high from the cycle after an accepted start until the done cycle. A start that arrives while busy has no effect. A start in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-walk pulse |
| va_i | input | 32 | Virtual address to translate |
| base0_i | input | 32 | Table base 0 |
| base1_i | input | 32 | Table base 1 |
| limit0_i | input | 32 | Highest VA served by base 0 |
| mask0_i | input | 32 | Mask applied to base 0 |
| mask1_i | input | 32 | Mask applied to base 1 |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | 32 | Read request byte address of a word |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data (descriptor) |
| done_o | output | 1 | One-cycle completion pulse |
| pa_o | output | 32 | Physical address result |
| fault_o | output | 1 | Walk ended in a fault |
| cause_o | output | 2 | 0 none, 1 first-level fault, 2 second-level fault, 3 supersection range fault |
| busy_o | output | 1 | Walk in progress |

## Verification
The checker assumes the memory returns exactly one response for each accepted request, and only while that read is outstanding. It also assumes no response ever arrives in the same cycle as its request. The bench's memory model keeps to this rule. It answers each accepted request once, after a random delay of one to three cycles, and it drops ready at random so that request stalls occur. Table bases, masks and the limit change only while the walker is idle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned XLEN         = 32;
  localparam int unsigned WORD_SHIFT   = 2;
  localparam int unsigned L1_IDX_LSB   = 20;
  localparam int unsigned SUPER_LSB    = 24;
  localparam int unsigned LARGE_LSB    = 16;
  localparam int unsigned SMALL_LSB    = 12;
  localparam int unsigned L2_TBL_LSB   = 10;
  localparam int unsigned SUPER_BIT    = 18;
  localparam int unsigned SX_LO_LSB    = 5;
  localparam int unsigned SX_LO_MSB    = 8;
  localparam int unsigned VA_KEEP      = SUPER_LSB;
  localparam int unsigned L1_IDX_W     = XLEN - L1_IDX_LSB;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_L1    = 2'd1,
    CAUSE_L2    = 2'd2,
    CAUSE_SUPER = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT
  } walk_st_e;

  typedef struct packed {
    logic            last;
    logic            fault;
    cause_e          cause;
    logic [XLEN-1:0] pa;
    logic [XLEN-1:0] next_addr;
  } dec_s;

endpackage

// File: rtl/xlat_select.sv
module xlat_select
  import xlat_pkg::*;
(
  input  logic [XLEN-1:0] va_i,
  input  logic [XLEN-1:0] base0_i,
  input  logic [XLEN-1:0] base1_i,
  input  logic [XLEN-1:0] limit0_i,
  input  logic [XLEN-1:0] mask0_i,
  input  logic [XLEN-1:0] mask1_i,
  output logic [XLEN-1:0] l1_addr_o
);

  logic            use_hi;
  logic [XLEN-1:0] tbl_base;
  logic [XLEN-1:0] va_mask;
  logic [XLEN-1:0] va_kept;
  logic            unused_low;

  // upper table only when strictly above the lower region's bound
  assign use_hi     = va_i > limit0_i;
  assign tbl_base   = use_hi ? (base1_i & mask1_i) : (base0_i & mask0_i);
  assign va_mask    = use_hi ? {XLEN{1'b1}} : limit0_i;
  assign va_kept    = va_i & va_mask;
  assign unused_low = ^va_kept[L1_IDX_LSB-1:0];

  assign l1_addr_o = tbl_base |
                     (XLEN'(va_kept[XLEN-1:L1_IDX_LSB]) << WORD_SHIFT);

endmodule

// File: rtl/xlat_decode.sv
module xlat_decode
  import xlat_pkg::*;
#(
  parameter int unsigned LEVEL = 1
)(
  input  logic [XLEN-1:0]    desc_i,
  input  logic [VA_KEEP-1:0] va_i,
  output dec_s               dec_o
);

  generate
    if (LEVEL == 1) begin : g_l1
      logic is_flt;
      logic is_sect;
      logic is_super;
      logic ext_bad;
      logic unused_l1;

      assign is_flt    = desc_i[1:0] == 2'b00;
      assign is_sect   = desc_i[1] & ~desc_i[SUPER_BIT];
      assign is_super  = desc_i[1] &  desc_i[SUPER_BIT];
      assign ext_bad   = (|desc_i[SUPER_LSB-1:L1_IDX_LSB]) | (|desc_i[SX_LO_MSB:SX_LO_LSB]);
      assign unused_l1 = ^{desc_i[L2_TBL_LSB-1], desc_i[SX_LO_LSB-1:2]};

      always_comb begin
        dec_o = '0;
        if (is_flt) begin
          dec_o.last  = 1'b1;
          dec_o.fault = 1'b1;
          dec_o.cause = CAUSE_L1;
        end else if (is_sect) begin
          dec_o.last = 1'b1;
          dec_o.pa   = {desc_i[XLEN-1:L1_IDX_LSB], va_i[L1_IDX_LSB-1:0]};
        end else if (is_super) begin
          dec_o.last = 1'b1;
          if (ext_bad) begin
            dec_o.fault = 1'b1;
            dec_o.cause = CAUSE_SUPER;
          end else begin
            dec_o.pa = {desc_i[XLEN-1:SUPER_LSB], va_i[SUPER_LSB-1:0]};
          end
        end else begin
          dec_o.next_addr = {desc_i[XLEN-1:L2_TBL_LSB],
                             va_i[L1_IDX_LSB-1:SMALL_LSB],
                             {WORD_SHIFT{1'b0}}};
        end
      end
    end else begin : g_l2
      logic unused_l2;
      assign unused_l2 = ^{desc_i[SMALL_LSB-1:2], va_i[VA_KEEP-1:LARGE_LSB]};

      always_comb begin
        dec_o      = '0;
        dec_o.last = 1'b1;
        unique case (desc_i[1:0])
          2'b00: begin
            dec_o.fault = 1'b1;
            dec_o.cause = CAUSE_L2;
          end
          2'b01:   dec_o.pa = {desc_i[XLEN-1:LARGE_LSB], va_i[LARGE_LSB-1:0]};
          default: dec_o.pa = {desc_i[XLEN-1:SMALL_LSB], va_i[SMALL_LSB-1:0]};
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [XLEN-1:0] va_i,
  input  logic [XLEN-1:0] base0_i,
  input  logic [XLEN-1:0] base1_i,
  input  logic [XLEN-1:0] limit0_i,
  input  logic [XLEN-1:0] mask0_i,
  input  logic [XLEN-1:0] mask1_i,
  output logic            mem_req_valid_o,
  output logic [XLEN-1:0] mem_req_addr_o,
  input  logic            mem_req_ready_i,
  input  logic            mem_rsp_valid_i,
  input  logic [XLEN-1:0] mem_rsp_data_i,
  output logic            done_o,
  output logic [XLEN-1:0] pa_o,
  output logic            fault_o,
  output logic [1:0]      cause_o,
  output logic            busy_o
);

  walk_st_e           state_q, state_d;
  logic [VA_KEEP-1:0] va_q, va_d;
  logic [XLEN-1:0]    addr_q, addr_d;
  logic               done_q;
  logic               res_en;
  dec_s               res_sel;
  logic [XLEN-1:0]    pa_q;
  logic               fault_q;
  cause_e             cause_q;
  logic               va_en, addr_en;

  logic [XLEN-1:0]    l1_addr;
  dec_s               dec1, dec2;
  logic               unused_dec;

  xlat_select u_sel (
    .va_i      (va_i),
    .base0_i   (base0_i),
    .base1_i   (base1_i),
    .limit0_i  (limit0_i),
    .mask0_i   (mask0_i),
    .mask1_i   (mask1_i),
    .l1_addr_o (l1_addr)
  );

  xlat_decode #(.LEVEL(1)) u_dec1 (
    .desc_i (mem_rsp_data_i),
    .va_i   (va_q),
    .dec_o  (dec1)
  );

  xlat_decode #(.LEVEL(2)) u_dec2 (
    .desc_i (mem_rsp_data_i),
    .va_i   (va_q),
    .dec_o  (dec2)
  );

  assign unused_dec = ^{dec2.next_addr, dec2.last};

  // next-state logic
  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    addr_d  = addr_q;
    va_en   = 1'b0;
    addr_en = 1'b0;
    res_en  = 1'b0;
    res_sel = dec1;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          va_d    = va_i[VA_KEEP-1:0];
          addr_d  = l1_addr;
          va_en   = 1'b1;
          addr_en = 1'b1;
          state_d = ST_L1_REQ;
        end
      end
      ST_L1_REQ:  if (mem_req_ready_i) state_d = ST_L1_WAIT;
      ST_L1_WAIT: begin
        if (mem_rsp_valid_i) begin
          if (dec1.last) begin
            res_en  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            addr_d  = dec1.next_addr;
            addr_en = 1'b1;
            state_d = ST_L2_REQ;
          end
        end
      end
      ST_L2_REQ:  if (mem_req_ready_i) state_d = ST_L2_WAIT;
      ST_L2_WAIT: begin
        if (mem_rsp_valid_i) begin
          res_en  = 1'b1;
          res_sel = dec2;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      va_q    <= '0;
      addr_q  <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      done_q  <= res_en;
      if (va_en)   va_q   <= va_d;
      if (addr_en) addr_q <= addr_d;
      if (res_en) begin
        pa_q    <= res_sel.pa;
        fault_q <= res_sel.fault;
        cause_q <= res_sel.cause;
      end
    end
  end

  assign mem_req_valid_o = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_req_addr_o  = addr_q;
  assign done_o          = done_q;
  assign pa_o            = pa_q;
  assign fault_o         = fault_q;
  assign cause_o         = cause_q;
  assign busy_o          = state_q != ST_IDLE;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            mem_req_valid_o,
  input logic [XLEN-1:0] mem_req_addr_o,
  input logic            mem_req_ready_i,
  input logic            mem_rsp_valid_i,
  input logic            done_o,
  input logic [XLEN-1:0] pa_o,
  input logic            fault_o,
  input logic [1:0]      cause_o,
  input logic            busy_o
);

  logic [1:0] rd_cnt;
  logic       outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      outst  <= 1'b0;
    end else begin
      if (start_i && !busy_o)                      rd_cnt <= '0;
      else if (mem_req_valid_o && mem_req_ready_i) rd_cnt <= rd_cnt + 2'd1;
      if (mem_req_valid_o && mem_req_ready_i) outst <= 1'b1;
      else if (mem_rsp_valid_i)               outst <= 1'b0;
    end
  end

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !mem_req_valid_o);

  a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r12_ok_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o |-> cause_o == 2'd0);

  a_r12_fault_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && fault_o |-> pa_o == '0 && cause_o != 2'd0);

  a_r3_l1_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cause_o == 2'd1 |-> rd_cnt == 2'd1);

  a_r6_super_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cause_o == 2'd3 |-> rd_cnt == 2'd1);

  a_r8_l2_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && cause_o == 2'd2 |-> rd_cnt == 2'd2);

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_valid_o);

endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] va_i, base0, base1, lim0, m0, m1;
  logic        mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
  logic [31:0] mem_req_addr_o, mem_rsp_data_i;
  logic        done_o, fault_o, busy_o;
  logic [31:0] pa_o;
  logic [1:0]  cause_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i),
    .base0_i(base0), .base1_i(base1), .limit0_i(lim0), .mask0_i(m0), .mask1_i(m1),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o), .pa_o(pa_o),
    .fault_o(fault_o), .cause_o(cause_o), .busy_o(busy_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  logic [31:0] mem [logic [31:0]];

  // model state
  bit          want_start;
  logic [31:0] va_drv;
  bit          model_busy, acc_prev, exp_done_now, exp_done_next;
  int          n_exp, rd_idx;
  logic [31:0] ea1, ea2, epa;
  bit          ef;
  logic [1:0]  ec;
  string       etag;
  bit          pend;
  int          cnt;
  logic [31:0] pend_addr;
  bit          seen_done;
  logic [31:0] got_pa;
  bit          got_f;
  logic [1:0]  got_c;

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // behavioural walk model written from the requirements
  function automatic void model(input logic [31:0] va, output logic [31:0] a1, output logic [31:0] a2,
                                output logic [31:0] pa, output int n, output bit f,
                                output logic [1:0] c, output string tag);
    logic [31:0] b, vm, d1, d2;
    if (va > lim0) begin b = base1 & m1; vm = 32'hFFFF_FFFF; end
    else           begin b = base0 & m0; vm = lim0; end
    a1 = b | (((va & vm) >> 20) << 2);
    d1 = rd(a1);
    n = 1; a2 = 0; pa = 0; f = 0; c = 0; tag = "";
    if (d1[1:0] == 2'b00) begin f = 1; c = 1; tag = "R3"; end
    else if (d1[1] && d1[18]) begin
      if (d1[23:20] != 0 || d1[8:5] != 0) begin f = 1; c = 3; tag = "R6"; end
      else begin pa = {d1[31:24], va[23:0]}; tag = "R5"; end
    end else if (d1[1]) begin pa = {d1[31:20], va[19:0]}; tag = "R4"; end
    else begin
      n = 2;
      a2 = {d1[31:10], va[19:12], 2'b00};
      d2 = rd(a2);
      if (d2[1:0] == 2'b00)      begin f = 1; c = 2; tag = "R8"; end
      else if (d2[1:0] == 2'b01) begin pa = {d2[31:16], va[15:0]}; tag = "R9"; end
      else                       begin pa = {d2[31:12], va[11:0]}; tag = "R10"; end
    end
  endfunction

  // one clock: compare outputs, act as memory, drive start
  task automatic tick();
    @(negedge clk);
    exp_done_now  = exp_done_next;
    exp_done_next = 0;
    if (acc_prev) model_busy = 1;
    acc_prev = 0;
    if (exp_done_now) model_busy = 0;
    chk("R12 done timing", done_o === exp_done_now, {31'b0, done_o}, {31'b0, exp_done_now});
    chk("R13 busy", busy_o === model_busy, {31'b0, busy_o}, {31'b0, model_busy});
    if (!model_busy)
      chk("R11 no request when idle", mem_req_valid_o === 1'b0, {31'b0, mem_req_valid_o}, 32'h0);
    if (done_o && exp_done_now) begin
      seen_done = 1; got_pa = pa_o; got_f = fault_o; got_c = cause_o;
      chk({etag, " pa vs model"}, pa_o === epa, pa_o, epa);
      chk({etag, " fault vs model"}, fault_o === ef, {31'b0, fault_o}, {31'b0, ef});
      chk({etag, " cause vs model"}, cause_o === ec, {30'b0, cause_o}, {30'b0, ec});
    end
    mem_rsp_valid_i = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = rd(pend_addr);
        pend = 0;
        if (rd_idx == n_exp) exp_done_next = 1;
      end else cnt--;
    end
    mem_req_ready_i = ($urandom % 4) != 0;
    if (mem_req_valid_o && mem_req_ready_i) begin
      rd_idx++;
      chk("R11 read count", rd_idx <= n_exp, rd_idx, n_exp);
      chk("R11 single outstanding", !pend, {31'b0, pend}, 32'h0);
      if (rd_idx == 1) chk("R1 R2 L1 address", mem_req_addr_o === ea1, mem_req_addr_o, ea1);
      else             chk("R7 L2 address", mem_req_addr_o === ea2, mem_req_addr_o, ea2);
      pend = 1; cnt = $urandom % 3; pend_addr = mem_req_addr_o;
    end
    start_i = want_start;
    va_i    = va_drv;
    if (want_start && !model_busy) begin
      model(va_drv, ea1, ea2, epa, n_exp, ef, ec, etag);
      rd_idx = 0; acc_prev = 1;
    end
  endtask

  task automatic finish_walk(input logic [31:0] xpa, input bit xf, input logic [1:0] xc, input string tag);
    for (int i = 0; i < 60 && !seen_done; i++) tick();
    chk({tag, " completed"}, seen_done, {31'b0, seen_done}, 32'h1);
    chk({tag, " pa"}, got_pa === xpa, got_pa, xpa);
    chk({tag, " fault"}, got_f === xf, {31'b0, got_f}, {31'b0, xf});
    chk({tag, " cause"}, got_c === xc, {30'b0, got_c}, {30'b0, xc});
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] xpa, input bit xf,
                      input logic [1:0] xc, input string tag);
    want_start = 1; va_drv = va; seen_done = 0;
    tick();
    want_start = 0;
    finish_walk(xpa, xf, xc, tag);
  endtask

  initial begin
    for (int w = 0; w < 100000; w++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R12 actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; va_i = 0;
    mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_data_i = 0;
    base0 = 32'h0000_4000; base1 = 32'h0001_0000; lim0 = 32'h7FFF_FFFF;
    m0 = 32'hFFFF_C000; m1 = 32'hFFFF_C000;
    want_start = 0; va_drv = 0; model_busy = 0; acc_prev = 0;
    exp_done_now = 0; exp_done_next = 0; n_exp = 0; rd_idx = 0; pend = 0; cnt = 0;
    ea1 = 0; ea2 = 0; epa = 0; ef = 0; ec = 0; etag = "";
    // table contents
    mem[32'h0000_448C] = 32'hABC0_0002;  // section
    mem[32'h0000_44D0] = 32'hCD04_0002;  // supersection
    mem[32'h0000_4500] = 32'hCD14_0002;  // supersection, bit 20 set
    mem[32'h0000_4540] = 32'hCD04_0022;  // supersection, bit 5 set
    mem[32'h0000_4580] = 32'hFFFF_FFFC;  // type 00
    mem[32'h0000_4828] = 32'h0008_0001;  // pointer to L2 table at 0x80000
    mem[32'h0008_02F0] = 32'h5555_5002;  // small page (10)
    mem[32'h0008_02F4] = 32'h6666_6003;  // small page (11)
    mem[32'h0008_031C] = 32'h7777_0001;  // large page
    mem[32'h0008_0320] = 32'h1234_5000;  // L2 type 00
    mem[32'h0001_2004] = 32'h0AA0_0002;  // base 1 section
    mem[32'h0000_5FFC] = 32'h0BB0_0002;  // base 0 top entry
    mem[32'h0000_4004] = 32'h0CC0_0002;  // range-masked entry
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R12 reset done", done_o === 1'b0, {31'b0, done_o}, 32'h0);
    chk("R13 reset busy", busy_o === 1'b0, {31'b0, busy_o}, 32'h0);
    chk("R11 reset request", mem_req_valid_o === 1'b0, {31'b0, mem_req_valid_o}, 32'h0);
    chk("R12 reset pa", pa_o === 32'h0, pa_o, 32'h0);

    walk(32'h1234_5678, 32'hABC4_5678, 0, 2'd0, "R4 section");
    walk(32'h1345_6789, 32'hCD45_6789, 0, 2'd0, "R5 supersection");
    walk(32'h1400_0000, 32'h0, 1, 2'd3, "R6 ext bits 23:20");
    walk(32'h1500_0000, 32'h0, 1, 2'd3, "R6 ext bits 8:5");
    walk(32'h1600_0000, 32'h0, 1, 2'd1, "R3 L1 fault");
    walk(32'h20AB_C123, 32'h5555_5123, 0, 2'd0, "R7 R10 small page");
    walk(32'h20AB_D456, 32'h6666_6456, 0, 2'd0, "R10 small page type 11");
    walk(32'h20AC_7890, 32'h7777_7890, 0, 2'd0, "R9 large page");
    walk(32'h20AC_8000, 32'h0, 1, 2'd2, "R8 L2 fault");
    walk(32'h8010_0ABC, 32'h0AA0_0ABC, 0, 2'd0, "R1 above limit base1");
    walk(32'h7FFF_FFFF, 32'h0BBF_FFFF, 0, 2'd0, "R1 equal limit base0");
    base0 = 32'h0000_7FFF;  // mask clears low bits to 0x4000
    walk(32'h1234_5678, 32'hABC4_5678, 0, 2'd0, "R2 base mask");
    base0 = 32'h0000_4000;
    lim0 = 32'h5FFF_FFFF;   // VA bit 29 is dropped by the range mask
    walk(32'h2010_0000, 32'h0CC0_0000, 0, 2'd0, "R2 range mask");
    lim0 = 32'h7FFF_FFFF;

    // start held high through a walk: ignored while busy, taken in the done cycle
    want_start = 1; va_drv = 32'h20AB_C123; seen_done = 0;
    tick();
    va_drv = 32'h1234_5678;
    finish_walk(32'h5555_5123, 0, 2'd0, "R13 start while busy ignored");
    want_start = 0; seen_done = 0;
    finish_walk(32'hABC4_5678, 0, 2'd0, "R13 start in done cycle");
    repeat (4) tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule